// File: doc/BRIEF.md
# Panel Raster Timing Generator

This block produces the raster timing for a 1024x600 display panel from a pixel clock near 51.2 MHz. A horizontal counter steps through every pixel clock of a line, and a vertical counter steps once per completed line. From these two counters the block derives a data-enable strobe, active-low horizontal and vertical sync pulses, a start-of-frame pulse, and the coordinates of the current active pixel. A pattern generator or frame reader uses the coordinates to present 24-bit colour data (8 bits per primary) alongside the strobe.

Each line starts with the sync pulse, then the back porch, then the active span, then the front porch. Frames are laid out the same way in lines. A static mode input chooses how the panel is told where pixels are. In enable-only mode (input high) both syncs stay high and only the strobe marks pixels. In sync mode (input low) the syncs pulse low in their windows. The active window is the same in both modes. The pulse, porch and active lengths are all elaboration parameters. The defaults are a 20-clock horizontal pulse, a 140-clock back porch, 1024 active clocks and a 160-clock front porch (1344 in total), and a 3-line vertical pulse, a 20-line back porch, 600 active lines and a 12-line front porch (635 in total). Reset is synchronous and active high. Every output comes from a register, so each output reflects the counter position of the previous clock.

Top module: `panel_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `de`=0, `hsync_n`=1, `vsync_n`=1, `sof`=0, `pix_x`=0 and `pix_y`=0, and both counters return to position 0.
- R2: A line lasts H_PW+H_BP+H_ACTIVE+H_FP pixel clocks. The horizontal position runs from 0 to that total minus 1 and then wraps to 0.
- R3: A frame lasts V_PW+V_BP+V_ACTIVE+V_FP lines. The vertical position advances only when the horizontal position wraps, and it wraps to 0 after its last line.
- R4: In sync mode (`mode_de`=0), `hsync_n` is low exactly for horizontal positions 0 to H_PW-1 of every line, and high otherwise.
- R5: In sync mode, `vsync_n` is low for every clock of lines 0 to V_PW-1, and high otherwise.
- R6: `de` is high exactly when the horizontal position lies in [H_PW+H_BP, H_PW+H_BP+H_ACTIVE) and the vertical position lies in [V_PW+V_BP, V_PW+V_BP+V_ACTIVE).
- R7: In enable-only mode (`mode_de`=1), `hsync_n` and `vsync_n` stay high on every clock, and `de` follows the same window as in R6.
- R8: While `de` is high, `pix_x` equals the horizontal position minus (H_PW+H_BP) and `pix_y` equals the vertical position minus (V_PW+V_BP). While `de` is low, both are 0.
- R9: `sof` is high for exactly one clock per frame, for the position horizontal 0, vertical 0.
- R10: All outputs are registered. An output in a given cycle describes the counter position of the previous cycle, so the first clock after reset is released presents position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_de | input | 1 | Timing mode: 1 enable-only, 0 sync pulses; held static outside reset |
| de | output | 1 | Active-pixel strobe |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| sof | output | 1 | One-clock start-of-frame pulse |
| pix_x | output | XW | Active column, 0 outside the active window |
| pix_y | output | YW | Active row, 0 outside the active window |

## Verification
The bench uses a reduced geometry of 16 clocks by 9 lines. It sweeps two full frames in each mode and recomputes every output from the clock count after reset. The corner cases are the window edges and the latency. If the strobe were opened one position early or closed one position late, the bench would see an extra `de` at the back-porch boundary or at the front-porch boundary. If the line wrap were off by one, the period would drift, and the bench would see every later frame start at the wrong clock. A sync left active in enable-only mode, or a coordinate counted from the pulse start rather than from the active start, would fail the first affected pixel. The bench also checks that `sof` stays low in the second frame's other clocks, which catches a pulse that fires at the start of every line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Selects how pixel positions are signalled downstream.
  typedef enum logic {
    TIMING_SYNC = 1'b0,
    TIMING_DE   = 1'b1
  } vtg_mode_e;

  // Bit width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned span_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/vtg_axis_counter.sv
// Wrapping position counter for one raster axis.
module vtg_axis_counter #(
  parameter int unsigned TOTAL = 1344,
  localparam int unsigned W    = vtg_pkg::span_bits(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] pos,
  output logic         at_end
);

  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  assign at_end = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (step)
      pos <= at_end ? '0 : pos + 1'b1;
  end

  // R2/R3: a stepped counter at its last value returns to zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (step && at_end) |=> (pos == '0));

  // R3: without a step the position holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));

endmodule

// File: rtl/vtg_window_decode.sv
// Classifies one axis position into the pulse and active windows.
module vtg_window_decode #(
  parameter int unsigned PULSE  = 20,
  parameter int unsigned BACK   = 140,
  parameter int unsigned ACTIVE = 1024,
  parameter int unsigned W      = 11,
  localparam int unsigned OW    = vtg_pkg::span_bits(ACTIVE)
) (
  input  logic [W-1:0]  pos,
  output logic          in_pulse,
  output logic          in_active,
  output logic [OW-1:0] offset
);

  localparam int unsigned  START = PULSE + BACK;
  localparam logic [W-1:0] A_LO  = W'(START);
  localparam logic [W-1:0] A_HI  = W'(START + ACTIVE);
  localparam logic [W-1:0] P_HI  = W'(PULSE);

  logic [W-1:0] rel;

  always_comb begin
    in_pulse  = (pos < P_HI);
    in_active = (pos >= A_LO) && (pos < A_HI);
    rel       = pos - A_LO;
    offset    = in_active ? OW'(rel) : '0;
  end

endmodule

// File: rtl/vtg_output_stage.sv
// Registers every timing output from the decoded counter state.
module vtg_output_stage #(
  parameter int unsigned XW = 10,
  parameter int unsigned YW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_de,
  input  logic          h_pulse,
  input  logic          v_pulse,
  input  logic          h_act,
  input  logic          v_act,
  input  logic          origin,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  output logic          de,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          sof,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y
);

  import vtg_pkg::*;

  vtg_mode_e mode;
  logic      act;

  always_comb begin
    mode = vtg_mode_e'(mode_de);
    act  = h_act && v_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de      <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      sof     <= 1'b0;
      pix_x   <= '0;
      pix_y   <= '0;
    end else begin
      de      <= act;
      hsync_n <= !((mode == TIMING_SYNC) && h_pulse);
      vsync_n <= !((mode == TIMING_SYNC) && v_pulse);
      sof     <= origin;
      pix_x   <= act ? x_in : '0;
      pix_y   <= act ? y_in : '0;
    end
  end

  // R7: enable-only mode keeps both syncs released
  p_sync_idle_r7: assert property (@(posedge clk) disable iff (rst)
    mode_de |=> (hsync_n && vsync_n));

  // R9: the frame pulse never lasts two clocks
  p_sof_single_r9: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

  // R8: coordinates are zero outside the strobe
  p_coord_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix_x == '0 && pix_y == '0));

  // R8: consecutive strobed pixels on one row step the column by one
  p_x_step_r8: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de)) |-> (pix_x == $past(pix_x) + 1'b1));

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
  parameter int unsigned H_ACTIVE = 1024,
  parameter int unsigned H_PW     = 20,
  parameter int unsigned H_BP     = 140,
  parameter int unsigned H_FP     = 160,
  parameter int unsigned V_ACTIVE = 600,
  parameter int unsigned V_PW     = 3,
  parameter int unsigned V_BP     = 20,
  parameter int unsigned V_FP     = 12,
  localparam int unsigned XW      = vtg_pkg::span_bits(H_ACTIVE),
  localparam int unsigned YW      = vtg_pkg::span_bits(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_de,
  output logic          de,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          sof,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y
);

  localparam int unsigned H_TOTAL = H_PW + H_BP + H_ACTIVE + H_FP;
  localparam int unsigned V_TOTAL = V_PW + V_BP + V_ACTIVE + V_FP;
  localparam int unsigned HW      = vtg_pkg::span_bits(H_TOTAL);
  localparam int unsigned VW      = vtg_pkg::span_bits(V_TOTAL);

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_end, v_end;
  logic          h_pulse, v_pulse, h_act, v_act;
  logic [XW-1:0] x_off;
  logic [YW-1:0] y_off;
  logic          origin;

  vtg_axis_counter #(.TOTAL(H_TOTAL)) u_hcount (
    .clk(clk), .rst(rst), .step(1'b1), .pos(h_pos), .at_end(h_end)
  );

  vtg_axis_counter #(.TOTAL(V_TOTAL)) u_vcount (
    .clk(clk), .rst(rst), .step(h_end), .pos(v_pos), .at_end(v_end)
  );

  vtg_window_decode #(.PULSE(H_PW), .BACK(H_BP), .ACTIVE(H_ACTIVE), .W(HW)) u_hdec (
    .pos(h_pos), .in_pulse(h_pulse), .in_active(h_act), .offset(x_off)
  );

  vtg_window_decode #(.PULSE(V_PW), .BACK(V_BP), .ACTIVE(V_ACTIVE), .W(VW)) u_vdec (
    .pos(v_pos), .in_pulse(v_pulse), .in_active(v_act), .offset(y_off)
  );

  assign origin = (h_pos == '0) && (v_pos == '0);

  vtg_output_stage #(.XW(XW), .YW(YW)) u_out (
    .clk(clk), .rst(rst), .mode_de(mode_de),
    .h_pulse(h_pulse), .v_pulse(v_pulse), .h_act(h_act), .v_act(v_act),
    .origin(origin), .x_in(x_off), .y_in(y_off),
    .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n), .sof(sof),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  // R3: the line counter advances only at the end of a line
  p_vstep_r3: assert property (@(posedge clk) disable iff (rst)
    (!h_end) |=> $stable(v_pos));

  // R9: the frame pulse falls in blanking, never on an active pixel
  p_sof_blank_r9: assert property (@(posedge clk) disable iff (rst)
    sof |-> !de);

  // R4: in sync mode the horizontal sync comes from the start of the line
  p_hsync_pos_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode_de && h_pos == '0) |=> !hsync_n);

  // R3: the end of the last line returns the frame to its origin
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (h_end && v_end) |=> origin);

endmodule

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HA = 8, HPW = 2, HBP = 3, HFP = 3;
  localparam int VA = 4, VPW = 1, VBP = 2, VFP = 2;
  localparam int HT = HPW + HBP + HA + HFP;
  localparam int VT = VPW + VBP + VA + VFP;
  localparam int FT = HT * VT;
  localparam int HS = HPW + HBP;
  localparam int VS = VPW + VBP;
  localparam int XW = $clog2(HA);
  localparam int YW = $clog2(VA);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_de = 1'b0;
  logic de, hsync_n, vsync_n, sof;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_timing_gen #(
    .H_ACTIVE(HA), .H_PW(HPW), .H_BP(HBP), .H_FP(HFP),
    .V_ACTIVE(VA), .V_PW(VPW), .V_BP(VBP), .V_FP(VFP)
  ) u_panel_timing_gen (
    .clk(clk), .rst(rst), .mode_de(mode_de),
    .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n), .sof(sof),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_in_mode(input logic m);
    @(negedge clk);
    rst = 1'b1;
    mode_de = m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle values under reset
    chk("R1", "de", de, 0);
    chk("R1", "hsync_n", hsync_n, 1);
    chk("R1", "vsync_n", vsync_n, 1);
    chk("R1", "sof", sof, 0);
    chk("R1", "pix_x", pix_x, 0);
    chk("R1", "pix_y", pix_y, 0);
    rst = 1'b0;
  endtask

  // n: clock edges since reset release; outputs show position n-1 (R10)
  task automatic sweep(input logic m, input int frames);
    for (int n = 1; n <= frames * FT + 2; n++) begin
      int idx, h, v;
      bit act;
      @(posedge clk);
      @(negedge clk);
      idx = (n - 1) % FT;
      h = idx % HT;          // R2
      v = idx / HT;          // R3
      act = (h >= HS) && (h < HS + HA) && (v >= VS) && (v < VS + VA);
      chk(m ? "R7" : "R6", "de", de, int'(act));
      if (m) begin
        chk("R7", "hsync_n", hsync_n, 1);
        chk("R7", "vsync_n", vsync_n, 1);
      end else begin
        chk("R4", "hsync_n", hsync_n, (h < HPW) ? 0 : 1);
        chk("R5", "vsync_n", vsync_n, (v < VPW) ? 0 : 1);
      end
      chk("R8", "pix_x", pix_x, act ? h - HS : 0);
      chk("R8", "pix_y", pix_y, act ? v - VS : 0);
      chk((n == 1) ? "R10" : "R9", "sof", sof, (idx == 0) ? 1 : 0);
    end
  endtask

  initial begin
    reset_in_mode(1'b0);
    sweep(1'b0, 2);
    reset_in_mode(1'b1);
    sweep(1'b1, 2);
    // R10: second reset restarts mid-frame; sync mode again, one frame
    reset_in_mode(1'b0);
    sweep(1'b0, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule